// File: doc/BRIEF.md
# Reload-Capture Down Counter Timer

A down counter for timing measurement. It counts down by one on each cycle where the prescaler tick is high. A reload register holds the value the counter restarts from. A capture register takes a snapshot of the count when an external strobe arrives. Two event pins are synchronised to the system clock. Each pin has a programmable active edge, rising or falling. A software run bit enables the counter and the event pins. A reload-enable bit selects between two kinds of operation:

- **Free-running:** the pins only take snapshots of the count.
- **Reload-controlled:** the counter restarts from the reload register. The restart comes from software, pin 1 or pin 2.

Each event type has a sticky flag and an overrun error flag. Software clears these flags through a small register write port.

Software uses a write interface with a 2-bit address:

- **Address 0** is control. Bit 0 is run. Bit 1 is reload-enable. Bits 3:2 are the restart select. Bit 4 is the pin 1 polarity and bit 5 is the pin 2 polarity; in both, 1 means the rising edge is active and 0 means the falling edge is active.
- **Address 1** writes the reload register.
- **Address 2** clears flags: a 1 in a bit position clears that flag.

The flag vector has four bits:

- bit 0: pin 1 event flag
- bit 1: pin 1 error flag
- bit 2: pin 2 event flag
- bit 3: pin 2 error flag

A pin change that is driven between clock edges takes effect on the third rising edge after the change.

Top module: `rct_timer`

## Requirements
- R1: After reset, the count, capture register, reload register and all four flags are zero. While run is set, each cycle with the tick high decrements the count by one, and the count wraps from 0000h to FFFFh.
- R2: With reload-enable clear, an active pin 1 edge acts only when the pin 1 flag (bit 0) and the pin 1 error flag (bit 1) are both clear. It then copies the current count into the reload register and sets bit 0. If bit 0 is already set, the edge sets bit 1 instead and copies nothing. In this mode, no pin event changes the count.
- R3: While run is clear, the tick and both pins have no effect: the count holds and no flag is set.
- R4: With reload-enable set and restart select 01, every active pin 1 edge loads the count from the reload register and sets flag bit 0.
- R5: A hardware reload that occurs while flag bit 0 is already set also sets error bit 1 in the same cycle. The reload still happens.
- R6: In any mode, an active pin 2 edge copies the current count into the capture register and sets flag bit 2, provided that bits 2 and 3 are both clear.
- R7: A pin 2 edge that arrives while bit 2 is set sets error bit 3 and captures nothing. No capture takes place until software has cleared both bit 2 and bit 3.
- R8: When a pin 2 capture and a reload fall on the same cycle, the capture register receives the count from before the reload, and the count takes the reload value.
- R9: With reload-enable set, pin events never write the reload register.
- R10: The active edge of each pin follows its polarity bit: 1 selects rising and 0 selects falling. An edge of the other direction has no effect.
- R11: With reload-enable set and restart select 10, an active pin 2 edge reloads the count, sets bit 0 (with the R5 error rule), and captures under the R6 and R7 rules.
- R12: With reload-enable set and restart select 00 or 11, a control write that sets run while run was clear loads the count from the reload register.
- R13: A write to address 2 clears exactly the flag bits where the data holds 1. Bits where the data holds 0 keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaler enable tick |
| evt1_i | input | 1 | External event pin 1 (asynchronous) |
| evt2_i | input | 1 | External event pin 2 (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Register write data |
| count_o | output | 16 | Current count |
| capture_o | output | 16 | Capture register |
| reload_o | output | 16 | Reload register |
| flags_o | output | 4 | Pin 1 flag, pin 1 error, pin 2 flag, pin 2 error |

## Verification
The hardest state to reach is the capture lockout. Software has cleared only one of the two pin 2 flags, and a further strobe must still be refused. Reaching it takes an ordered sequence:

1. A strobe that captures.
2. A second strobe that only raises the error flag.
3. A write that clears only the event flag.
4. A third strobe.
5. A write that clears the error flag, followed by a fourth strobe that must capture again.

The bench stops the tick around every strobe so that the expected count is known exactly. It also drives both pins on the same cycle to reach the case where a capture and a reload coincide. Random phases then mix random tick patterns, random reload values and repeated reload/capture pairs.

// File: rtl/rct_pkg.sv
package rct_pkg;
  // control register layout, bit 0 (run) to bit 5 (pin 2 polarity)
  typedef struct packed {
    logic [1:0] pol;     // [1] pin 2, [0] pin 1 : 1 = rising active
    logic [1:0] sel;     // restart source when reload enabled
    logic       rld_en;
    logic       run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned NUM_FLAGS = 4;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_CLEAR  = 2'd2;

  localparam logic [1:0] SEL_SW   = 2'b00;
  localparam logic [1:0] SEL_PIN1 = 2'b01;
  localparam logic [1:0] SEL_PIN2 = 2'b10;
endpackage

// File: rtl/rct_edge.sv
module rct_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_act_i,
  output logic edge_o
);
  logic sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    if (rise_act_i) edge_o = sync2_q & ~prev_q;
    else            edge_o = ~sync2_q & prev_q;
  end
endmodule

// File: rtl/rct_count.sv
module rct_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rct_evt.sv
module rct_evt
  import rct_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrl_t                ctrl_i,
  input  logic                 ev1_i,
  input  logic                 ev2_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 rld_wr_i,
  input  logic [CNT_W-1:0]     rld_wdata_i,
  input  logic                 clr_wr_i,
  input  logic [NUM_FLAGS-1:0] clr_mask_i,
  output logic                 hw_reload_o,
  output logic [CNT_W-1:0]     rld_o,
  output logic [CNT_W-1:0]     cap_o,
  output logic [NUM_FLAGS-1:0] flags_o
);
  logic [CNT_W-1:0]     rld_q, rld_d, cap_q, cap_d;
  logic [NUM_FLAGS-1:0] flg_q, flg_d, set_v, clr_v;
  logic hw_reload, free_ev1, free_ok, cap_ok;

  always_comb begin
    hw_reload = ctrl_i.rld_en &
                (((ctrl_i.sel == SEL_PIN1) & ev1_i) |
                 ((ctrl_i.sel == SEL_PIN2) & ev2_i));
    free_ev1  = ~ctrl_i.rld_en & ev1_i;
    free_ok   = ~flg_q[0] & ~flg_q[1];
    cap_ok    = ~flg_q[2] & ~flg_q[3];

    set_v    = '0;
    set_v[0] = hw_reload | (free_ev1 & free_ok);
    set_v[1] = (hw_reload | free_ev1) & flg_q[0];
    set_v[2] = ev2_i & cap_ok;
    set_v[3] = ev2_i & flg_q[2];

    clr_v = clr_wr_i ? clr_mask_i : '0;
    flg_d = (flg_q & ~clr_v) | set_v;

    rld_d = rld_q;
    if (free_ev1 & free_ok) rld_d = cnt_i;
    else if (rld_wr_i)      rld_d = rld_wdata_i;

    cap_d = cap_q;
    if (ev2_i & cap_ok) cap_d = cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
      cap_q <= '0;
      flg_q <= '0;
    end else begin
      rld_q <= rld_d;
      cap_q <= cap_d;
      flg_q <= flg_d;
    end
  end

  assign hw_reload_o = hw_reload;
  assign rld_o       = rld_q;
  assign cap_o       = cap_q;
  assign flags_o     = flg_q;
endmodule

// File: rtl/rct_timer.sv
module rct_timer
  import rct_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 evt1_i,
  input  logic                 evt2_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  output logic [CNT_W-1:0]     count_o,
  output logic [CNT_W-1:0]     capture_o,
  output logic [CNT_W-1:0]     reload_o,
  output logic [NUM_FLAGS-1:0] flags_o
);
  localparam int unsigned NPIN = 2;

  ctrl_t ctrl_q, ctrl_d, ctrl_wr;
  logic  ctrl_we, rld_we, clr_we, sw_restart, hw_reload, run_q;
  logic [NPIN-1:0] pins, edges, ev_act;

  assign ctrl_wr = ctrl_t'(wr_data_i[CTRL_W-1:0]);
  assign ctrl_we = wr_en_i & (wr_addr_i == ADDR_W'(ADDR_CTRL));
  assign rld_we  = wr_en_i & (wr_addr_i == ADDR_W'(ADDR_RELOAD));
  assign clr_we  = wr_en_i & (wr_addr_i == ADDR_W'(ADDR_CLEAR));
  assign run_q   = ctrl_q.run;

  always_comb begin
    ctrl_d = ctrl_we ? ctrl_wr : ctrl_q;
    sw_restart = ctrl_we & ctrl_wr.run & ~ctrl_q.run & ctrl_wr.rld_en &
                 (ctrl_wr.sel != SEL_PIN1) & (ctrl_wr.sel != SEL_PIN2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign pins = {evt2_i, evt1_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    rct_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pins[g]),
      .rise_act_i (ctrl_q.pol[g]),
      .edge_o     (edges[g])
    );
    assign ev_act[g] = edges[g] & run_q;
  end

  rct_evt #(.CNT_W(CNT_W)) u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_i      (ctrl_q),
    .ev1_i       (ev_act[0]),
    .ev2_i       (ev_act[1]),
    .cnt_i       (count_o),
    .rld_wr_i    (rld_we),
    .rld_wdata_i (wr_data_i),
    .clr_wr_i    (clr_we),
    .clr_mask_i  (wr_data_i[NUM_FLAGS-1:0]),
    .hw_reload_o (hw_reload),
    .rld_o       (reload_o),
    .cap_o       (capture_o),
    .flags_o     (flags_o)
  );

  rct_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (hw_reload | sw_restart),
    .load_val_i (reload_o),
    .dec_i      (tick_i & run_q),
    .cnt_o      (count_o)
  );
endmodule

// File: rtl/rct_timer_chk.sv
module rct_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] capture_i,
  input logic [3:0]       flags_i
);
  AST_IDLE_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_en_i) |=> $stable(count_i)); // R3

  AST_FLAG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags_i[0]) || $rose(flags_i[2])) |-> $past(run_i)); // R3

  AST_RLD_ERR_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_i[1]) |-> $past(flags_i[0])); // R5

  AST_CAP_ERR_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_i[3]) |-> $past(flags_i[2])); // R7

  AST_CAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_i[2] || flags_i[3]) |=> $stable(capture_i)); // R7
endmodule

bind rct_timer rct_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_i     (run_q),
  .wr_en_i   (wr_en_i),
  .count_i   (count_o),
  .capture_i (capture_o),
  .flags_i   (flags_o)
);

// File: tb/rct_timer_tb_top.sv
module rct_timer_tb_top;
  logic clk, rst_n, tick, p1, p2, wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data, count, cap, rld, exp_cnt, exp_cap, saved;
  logic [3:0]  flags;
  int n_tests, n_fail;
  bit done;

  rct_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .evt1_i(p1), .evt2_i(p2),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .count_o(count), .capture_o(cap), .reload_o(rld), .flags_o(flags)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pins(input logic b1, input logic b2);
    @(negedge clk); p1 = b1; p2 = b2;
    repeat (5) @(negedge clk);
  endtask

  // run n random-tick cycles, tracking the expected count
  task automatic ticks(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = rnd ? 1'($urandom % 2) : 1'b1;
      if (tick) exp_cnt = exp_cnt - 16'd1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic logic [15:0] fl(input logic [3:0] f);
    return {12'd0, f};
  endfunction

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    tick = 0; p1 = 0; p2 = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count, 16'h0);
    check("R1 cap", cap, 16'h0);
    check("R1 reload", rld, 16'h0);
    check("R1 flags", fl(flags), 16'h0);

    // R3: not running, pins and tick do nothing
    wr(2'd0, 16'h0030);
    @(negedge clk); tick = 1'b1; repeat (4) @(negedge clk); tick = 1'b0;
    pins(1, 1); pins(0, 0);
    check("R3 count", count, 16'h0);
    check("R3 flags", fl(flags), 16'h0);
    check("R3 cap", cap, 16'h0);

    // R1 run free, wrap from zero
    wr(2'd0, 16'h0031);
    exp_cnt = 16'h0;
    ticks(1, 0);
    check("R1 wrap", count, 16'hFFFF);
    ticks(300, 1);
    check("R1 random count", count, exp_cnt);

    // R2 free mode pin 1 copies count into reload register
    pins(1, 0); pins(0, 0);
    check("R2 reload copy", rld, exp_cnt);
    check("R2 count untouched", count, exp_cnt);
    check("R2 flag", fl(flags), 16'h1);
    saved = exp_cnt;
    ticks(7, 0);
    pins(1, 0); pins(0, 0);
    check("R2 blocked copy", rld, saved);
    check("R2 error flag", fl(flags), 16'h3);
    // R13 partial then full clear
    wr(2'd2, 16'h0002);
    check("R13 partial clear", fl(flags), 16'h1);
    wr(2'd2, 16'h000F);
    check("R13 full clear", fl(flags), 16'h0);

    // R6 capture in free mode
    ticks(9, 1);
    pins(0, 1); pins(0, 0);
    check("R6 capture", cap, exp_cnt);
    check("R6 flag", fl(flags), 16'h4);
    exp_cap = exp_cnt;
    // R7 lockout sequence
    ticks(5, 0);
    pins(0, 1); pins(0, 0);
    check("R7 err flag", fl(flags), 16'hC);
    check("R7 no capture", cap, exp_cap);
    wr(2'd2, 16'h0004);
    ticks(3, 0);
    pins(0, 1); pins(0, 0);
    check("R7 still locked cap", cap, exp_cap);
    check("R7 still locked flags", fl(flags), 16'h8);
    wr(2'd2, 16'h0008);
    pins(0, 1); pins(0, 0);
    check("R7 capture resumes", cap, exp_cnt);
    check("R7 flags after resume", fl(flags), 16'h4);
    wr(2'd2, 16'h000F);

    // R4 / R5 / R9 reload on pin 1
    wr(2'd1, 16'h1234);
    wr(2'd0, 16'h0037);
    pins(1, 0); pins(0, 0);
    exp_cnt = 16'h1234;
    check("R4 reload", count, exp_cnt);
    check("R4 flag", fl(flags), 16'h1);
    ticks(3, 0);
    check("R4 counts from reload", count, 16'h1231);
    pins(1, 0); pins(0, 0);
    check("R5 reload still", count, 16'h1234);
    check("R5 error flag", fl(flags), 16'h3);
    check("R9 reload reg intact", rld, 16'h1234);
    wr(2'd2, 16'h000F);

    // R8 coincident capture and reload
    exp_cnt = 16'h1234;
    ticks(5, 0);
    pins(1, 1); pins(0, 0);
    check("R8 pre-reload capture", cap, 16'h122F);
    check("R8 count reloaded", count, 16'h1234);
    check("R8 flags", fl(flags), 16'h5);
    wr(2'd2, 16'h000F);

    // R10 falling polarity on pin 1
    wr(2'd0, 16'h0027);
    exp_cnt = 16'h1234;
    ticks(2, 0);
    pins(1, 0);
    check("R10 rising ignored", count, 16'h1232);
    check("R10 no flag", fl(flags), 16'h0);
    pins(0, 0);
    check("R10 falling reloads", count, 16'h1234);
    check("R10 flag", fl(flags), 16'h1);
    wr(2'd2, 16'h000F);

    // R11 restart on pin 2
    wr(2'd0, 16'h003B);
    exp_cnt = 16'h1234;
    ticks(4, 0);
    pins(0, 1); pins(0, 0);
    check("R11 capture", cap, 16'h1230);
    check("R11 reload", count, 16'h1234);
    check("R11 flags", fl(flags), 16'h5);
    wr(2'd2, 16'h000F);

    // R12 software restart
    wr(2'd0, 16'h0032);
    wr(2'd1, 16'h00AB);
    check("R12 idle count", count, 16'h1234);
    wr(2'd0, 16'h0033);
    check("R12 sw restart", count, 16'h00AB);

    // random reload / capture pairs in pin 1 mode
    wr(2'd0, 16'h0037);
    for (int k = 0; k < 20; k++) begin
      logic [15:0] rv;
      rv = 16'($urandom);
      wr(2'd1, rv);
      pins(1, 0); pins(0, 0);
      exp_cnt = rv;
      check("R4 random reload", count, rv);
      wr(2'd2, 16'h000F);
      ticks(1 + int'($urandom % 40), 1);
      pins(0, 1); pins(0, 0);
      check("R6 random capture", cap, exp_cnt);
      check("R6 random flags", fl(flags), 16'h4);
      wr(2'd2, 16'h000F);
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule